// File: doc/BRIEF.md
# SMBus Alert Latch and Alert-Response Responder

This block turns a set of status flags into an active-low SMBus alert request and answers the master's poll of the Alert Response Address (ARA, 7-bit 0001100). Each status flag has a matching enable bit. A rising edge on an enabled flag sets one pending-alert latch. While that latch is set, the block asks the open-drain alert pin to be pulled low. A flag that simply stays high does not re-arm the latch; only a new rising edge does.

A bus engine outside this block decodes the bus. When it sees a read of the ARA, it pulses `ara_match_i`. In that same cycle the block raises `ara_ack_o`, but only if an alert is pending. The block then offers one transmit byte on a valid/ready interface. The engine shifts the byte out MSB first and reports each bit with `bit_sent_i`. It reports lost arbitration with `arb_lost_i` and the end of the byte with `done_i`. A byte that completes all eight bits clears the latch, which releases the pin. A response that ends early leaves the alert pending, so the master can poll again.

Transmit back-pressure works as follows. Once `tx_valid_o` rises, it stays high and `tx_data_o` holds still until the engine takes the byte by asserting `tx_ready_i` in a cycle where `tx_valid_o` is high. The block never withdraws an offered byte. A configuration input can also hand the pin over to a plain general-purpose output level.

Top module: `smb_alert_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `alert_pull_o`, `ara_ack_o` and `tx_valid_o` are 0. A flag that is already high when reset ends does not raise an alert.
- R2: A 0-to-1 change on `status_i[k]` while `alert_en_i[k]` is 1 makes `alert_pull_o` 1 after the next rising clock edge (pin mode 0). The same change on a flag whose enable is 0 has no effect.
- R3: Once set, the alert stays pending after the status flags fall. Only a completed response or reset clears it.
- R4: `ara_ack_o` equals `ara_match_i` in the same cycle while an alert is pending and no response is in progress. It is 0 otherwise.
- R5: After an acknowledged match, `tx_valid_o` is 1 from the next cycle. `tx_data_o` is {1, 0, `dev_addr_i[4:0]`, 1}, bit 7 first on the wire. Data and valid hold until `tx_ready_i` is seen.
- R6: After the byte is taken, eight `bit_sent_i` pulses followed by `done_i` clear the alert. `alert_pull_o` is 0 from the cycle after `done_i`.
- R7: `arb_lost_i` during the byte ends the response. The alert stays pending, and the next match is acknowledged again.
- R8: `done_i` that arrives after fewer than eight `bit_sent_i` pulses ends the response without clearing the alert.
- R9: A qualified rising edge in the same cycle as the clearing `done_i` leaves the alert pending.
- R10: With `pin_mode_gpo_i` = 1, `alert_pull_o` is the inverse of `gpo_level_i`. The alert latch keeps working behind the mux, and its state shows again when the mode returns to 0.
- R11: A match that arrives while a response is in progress is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| status_i | input | 6 | Status flags, one per alert source |
| alert_en_i | input | 6 | Per-source alert enables |
| dev_addr_i | input | 5 | Configured low five bits of the device address |
| pin_mode_gpo_i | input | 1 | 1: pin driven by `gpo_level_i`; 0: pin driven by the alert latch |
| gpo_level_i | input | 1 | Pin level in general-purpose mode (0 pulls low) |
| ara_match_i | input | 1 | Strobe: engine decoded a read of the Alert Response Address |
| ara_ack_o | output | 1 | Acknowledge the alert-response address this cycle |
| tx_valid_o | output | 1 | Transmit byte offered |
| tx_ready_i | input | 1 | Engine takes the offered byte |
| tx_data_o | output | 8 | Transmit byte, MSB first on the wire |
| bit_sent_i | input | 1 | Strobe: one bit of the byte was sent |
| arb_lost_i | input | 1 | Strobe: SDA read low while released, response abandoned |
| done_i | input | 1 | Strobe: engine finished the byte |
| alert_pull_o | output | 1 | Open-drain enable: 1 pulls the alert pin low |

## Verification
On every cycle, the assertions check four things. A rise of the latch must trace back to an enabled active flag, and a fall must follow a `done_i`. An acknowledge needs a pending alert and never overlaps an offered byte. An offered byte carries the fixed address framing and holds steady under back-pressure. The bench scenarios cover what needs a known sequence to judge: disabled sources, flags already high at reset, the eight-bit count before a clear, an abort on lost arbitration or an early done, the race between an edge and a clear, and hand-over of the pin to the general-purpose level. A seeded random phase then compares the pin against a bench model of the edge-and-enable rule.

// File: rtl/alert_resp_pkg.sv
package alert_resp_pkg;
  typedef enum logic [1:0] {
    RSP_IDLE  = 2'd0,
    RSP_OFFER = 2'd1,
    RSP_SEND  = 2'd2
  } rsp_state_t;

  // fixed upper bits of the device address
  localparam logic [1:0] ADDR_HI = 2'b10;
endpackage

// File: rtl/alert_edge_latch.sv
module alert_edge_latch #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] enable_i,
  input  logic               clear_i,
  output logic               pending_o
);
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] rise;
  logic               set_ev;

  // prev resets high so a flag already set at reset exit is not an edge
  always_comb begin
    rise   = status_i & ~prev_q & enable_i;
    set_ev = |rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '1;
      pending_o <= 1'b0;
    end else begin
      prev_q    <= status_i;
      // set wins over clear in the same cycle
      pending_o <= set_ev | (pending_o & ~clear_i);
    end
  end
endmodule

// File: rtl/ara_responder.sv
module ara_responder
  import alert_resp_pkg::*;
#(
  parameter int ADDR_LO_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pending_i,
  input  logic                 ara_match_i,
  input  logic [ADDR_LO_W-1:0] addr_lo_i,
  output logic                 ara_ack_o,
  output logic                 tx_valid_o,
  input  logic                 tx_ready_i,
  output logic [ADDR_LO_W+2:0] tx_data_o,
  input  logic                 bit_sent_i,
  input  logic                 arb_lost_i,
  input  logic                 done_i,
  output logic                 clear_o
);
  localparam int BYTE_W = ADDR_LO_W + 3;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  rsp_state_t           state_q;
  logic [CNT_W-1:0]     bits_q;
  logic [ADDR_LO_W-1:0] addr_q;
  logic                 full_byte;

  always_comb begin
    full_byte  = (bits_q == CNT_W'(BYTE_W));
    ara_ack_o  = (state_q == RSP_IDLE) && ara_match_i && pending_i;
    tx_valid_o = (state_q == RSP_OFFER);
    tx_data_o  = {ADDR_HI, addr_q, 1'b1};
    clear_o    = (state_q == RSP_SEND) && !arb_lost_i && done_i && full_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RSP_IDLE;
      bits_q  <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        RSP_IDLE: begin
          if (ara_ack_o) begin
            addr_q  <= addr_lo_i;
            state_q <= RSP_OFFER;
          end
        end
        RSP_OFFER: begin
          if (tx_ready_i) begin
            bits_q  <= '0;
            state_q <= RSP_SEND;
          end
        end
        RSP_SEND: begin
          if (arb_lost_i || done_i) begin
            state_q <= RSP_IDLE;
          end else if (bit_sent_i && !full_byte) begin
            bits_q <= bits_q + 1'b1;
          end
        end
        default: state_q <= RSP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/alert_pin_mux.sv
module alert_pin_mux (
  input  logic pending_i,
  input  logic gpo_mode_i,
  input  logic gpo_level_i,
  output logic pull_o
);
  always_comb pull_o = gpo_mode_i ? ~gpo_level_i : pending_i;
endmodule

// File: rtl/smb_alert_unit.sv
module smb_alert_unit #(
  parameter int NUM_SRC   = 6,
  parameter int ADDR_LO_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   status_i,
  input  logic [NUM_SRC-1:0]   alert_en_i,
  input  logic [ADDR_LO_W-1:0] dev_addr_i,
  input  logic                 pin_mode_gpo_i,
  input  logic                 gpo_level_i,
  input  logic                 ara_match_i,
  output logic                 ara_ack_o,
  output logic                 tx_valid_o,
  input  logic                 tx_ready_i,
  output logic [ADDR_LO_W+2:0] tx_data_o,
  input  logic                 bit_sent_i,
  input  logic                 arb_lost_i,
  input  logic                 done_i,
  output logic                 alert_pull_o
);
  logic pending;
  logic clear;

  alert_edge_latch #(.NUM_SRC(NUM_SRC)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_i  (status_i),
    .enable_i  (alert_en_i),
    .clear_i   (clear),
    .pending_o (pending)
  );

  ara_responder #(.ADDR_LO_W(ADDR_LO_W)) u_rsp (
    .clk         (clk),
    .rst_n       (rst_n),
    .pending_i   (pending),
    .ara_match_i (ara_match_i),
    .addr_lo_i   (dev_addr_i),
    .ara_ack_o   (ara_ack_o),
    .tx_valid_o  (tx_valid_o),
    .tx_ready_i  (tx_ready_i),
    .tx_data_o   (tx_data_o),
    .bit_sent_i  (bit_sent_i),
    .arb_lost_i  (arb_lost_i),
    .done_i      (done_i),
    .clear_o     (clear)
  );

  alert_pin_mux u_mux (
    .pending_i   (pending),
    .gpo_mode_i  (pin_mode_gpo_i),
    .gpo_level_i (gpo_level_i),
    .pull_o      (alert_pull_o)
  );
endmodule

// File: rtl/smb_alert_unit_chk.sv
module smb_alert_unit_chk #(
  parameter int NUM_SRC   = 6,
  parameter int ADDR_LO_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SRC-1:0]   status_i,
  input logic [NUM_SRC-1:0]   alert_en_i,
  input logic                 ara_ack_o,
  input logic                 tx_valid_o,
  input logic                 tx_ready_i,
  input logic [ADDR_LO_W+2:0] tx_data_o,
  input logic                 done_i,
  input logic                 pending
);
  localparam int BYTE_W = ADDR_LO_W + 3;

  a_r2_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(|(status_i & alert_en_i)));

  a_r6_fall_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(done_i));

  a_r4_ack_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ara_ack_o |-> pending);

  a_r5_byte_framing: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> (tx_data_o[BYTE_W-1 -: 2] == 2'b10) && tx_data_o[0]);

  a_r5_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  a_r11_no_ack_during_offer: assert property (@(posedge clk) disable iff (!rst_n)
    ara_ack_o |-> !tx_valid_o);
endmodule

bind smb_alert_unit smb_alert_unit_chk #(.NUM_SRC(NUM_SRC), .ADDR_LO_W(ADDR_LO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .status_i   (status_i),
  .alert_en_i (alert_en_i),
  .ara_ack_o  (ara_ack_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .done_i     (done_i),
  .pending    (pending)
);

// File: tb/smb_alert_unit_tb.sv
`timescale 1ns/1ps
module smb_alert_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] status = '0, en = '0;
  logic [4:0] addr = 5'b01011;
  logic       mode = 1'b0, lvl = 1'b1;
  logic       match = 1'b0, ready = 1'b0, bsent = 1'b0, arb = 1'b0, done = 1'b0;
  logic       ack, txv, pull;
  logic [7:0] txd;
  int         n_chk = 0, n_fail = 0;
  logic       pend_m;
  logic [5:0] prev_m;
  logic [31:0] seed_dummy;

  always #4 clk = ~clk;

  smb_alert_unit u_dut (
    .clk(clk), .rst_n(rst_n), .status_i(status), .alert_en_i(en),
    .dev_addr_i(addr), .pin_mode_gpo_i(mode), .gpo_level_i(lvl),
    .ara_match_i(match), .ara_ack_o(ack), .tx_valid_o(txv),
    .tx_ready_i(ready), .tx_data_o(txd), .bit_sent_i(bsent),
    .arb_lost_i(arb), .done_i(done), .alert_pull_o(pull)
  );

  function automatic logic [7:0] exp_byte(input logic [4:0] a);
    return {2'b10, a, 1'b1};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // acknowledged response; nbits bit strobes, then arb loss or done
  task automatic respond(input int nbits, input bit lose, input bit edge_at_done);
    match = 1'b1; #1;
    chk("R4 ack when pending", {7'd0, ack}, 8'd1);
    tick(); match = 1'b0; #1;
    chk("R5 valid after ack", {7'd0, txv}, 8'd1);
    chk("R5 byte", txd, exp_byte(addr));
    ready = 1'b1; tick(); ready = 1'b0;
    for (int i = 0; i < nbits; i++) begin bsent = 1'b1; tick(); end
    bsent = 1'b0;
    if (lose) begin arb = 1'b1; tick(); arb = 1'b0; end
    else begin
      if (edge_at_done) status[0] = 1'b1;
      done = 1'b1; tick(); done = 1'b0;
    end
    #1;
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'd1234);
    status = 6'h3F; en = 6'h3F;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pull in reset", {7'd0, pull}, 8'd0);
    chk("R1 valid in reset", {7'd0, txv}, 8'd0);
    rst_n = 1'b1;
    tick(); tick();
    chk("R1 high flag at reset exit", {7'd0, pull}, 8'd0);
    chk("R1 no valid", {7'd0, txv}, 8'd0);
    // R4: match without pending
    match = 1'b1; #1;
    chk("R4 no ack when idle", {7'd0, ack}, 8'd0);
    tick(); match = 1'b0; #1;
    chk("R4 no offer", {7'd0, txv}, 8'd0);
    // R2
    status = 6'h00; en = 6'b000001; tick();
    status[3] = 1'b1; tick();
    chk("R2 disabled source", {7'd0, pull}, 8'd0);
    status[0] = 1'b1; tick();
    chk("R2 enabled edge", {7'd0, pull}, 8'd1);
    status = 6'h00; tick(); tick();
    chk("R3 latched after fall", {7'd0, pull}, 8'd1);
    // R5 back-pressure and R11
    match = 1'b1; #1;
    chk("R4 ack", {7'd0, ack}, 8'd1);
    tick(); #1;
    chk("R11 no ack in offer", {7'd0, ack}, 8'd0);
    match = 1'b0;
    tick(); tick();
    chk("R5 valid held", {7'd0, txv}, 8'd1);
    chk("R5 data held", txd, exp_byte(addr));
    ready = 1'b1; tick(); ready = 1'b0; #1;
    chk("R5 valid drops after take", {7'd0, txv}, 8'd0);
    for (int i = 0; i < 8; i++) begin bsent = 1'b1; tick(); end
    bsent = 1'b0; #1;
    chk("R6 pending before done", {7'd0, pull}, 8'd1);
    done = 1'b1; tick(); done = 1'b0; #1;
    chk("R6 cleared after done", {7'd0, pull}, 8'd0);
    // R7: arbitration lost
    addr = 5'b10100;
    status[0] = 1'b1; tick(); status[0] = 1'b0; tick();
    chk("R2 second edge", {7'd0, pull}, 8'd1);
    respond(3, 1'b1, 1'b0);
    chk("R7 kept after arb loss", {7'd0, pull}, 8'd1);
    chk("R7 no valid after arb loss", {7'd0, txv}, 8'd0);
    // R8: early done
    respond(2, 1'b0, 1'b0);
    chk("R8 kept after early done", {7'd0, pull}, 8'd1);
    // R9: edge with clear
    respond(8, 1'b0, 1'b1);
    chk("R9 edge beats clear", {7'd0, pull}, 8'd1);
    status[0] = 1'b0; tick();
    respond(8, 1'b0, 1'b0);
    chk("R6 full clear", {7'd0, pull}, 8'd0);
    // R10
    mode = 1'b1; lvl = 1'b0; #1;
    chk("R10 gpo low", {7'd0, pull}, 8'd1);
    lvl = 1'b1; #1;
    chk("R10 gpo high", {7'd0, pull}, 8'd0);
    status[0] = 1'b1; tick(); #1;
    chk("R10 latch hidden", {7'd0, pull}, 8'd0);
    mode = 1'b0; #1;
    chk("R10 latch shown", {7'd0, pull}, 8'd1);
    // random phase, R2/R3 against bench model
    pend_m = 1'b1; prev_m = status;
    for (int c = 0; c < 400; c++) begin
      status = 6'($urandom);
      en = 6'($urandom);
      tick();
      pend_m = pend_m | (|(status & ~prev_m & en));
      prev_m = status;
      chk("R2 R3 random", {7'd0, pull}, {7'd0, pend_m});
      if (c == 200) begin
        status = 6'h00; tick(); prev_m = status;
        respond(8, 1'b0, 1'b0);
        pend_m = 1'b0;
        chk("R6 random clear", {7'd0, pull}, 8'd0);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule